// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block looks at the two oldest decoded instructions at the head of the decode queue and decides how many of them issue this clock. The older instruction always goes to the U pipe. The younger one goes to the V pipe in the same clock only if the pair passes every pairing rule. Otherwise only the older instruction issues, alone, and the younger one becomes the older slot on the next cycle, where it is checked again.

Each slot supplies only the fields that the rules actually read for that slot:

- **U slot:** class, destination register mask, displacement and immediate flags, and a branch flag.
- **V slot:** class, source and destination masks, displacement and immediate flags, and a prefix flag.

The decision is combinational from the slot inputs. The one exception is a stall request, which is registered first and takes effect one clock after it is sampled.

The outputs are a pair flag, a count of consumed instructions (0, 1 or 2) and a 3-bit reason code. The reason code names the first rule that blocked pairing.

Top module: `pair_check`

## Requirements
- R1: With both slots valid and every rule passing, pair_o is 1, count_o is 2 and reason_o is 0.
- R2: If either slot is not simple (`*_simple_i` = 0), the pair is refused: pair_o is 0, count_o is 1 and reason_o is 1.
- R3: If the V slot's source or destination mask overlaps the U slot's destination mask, the pair is refused with count_o 1 and reason_o 2. A U-slot read of a register that V writes does not block pairing.
- R4: If either slot has both its displacement flag and its immediate flag set, the pair is refused with count_o 1 and reason_o 3. A displacement in one slot and an immediate in the other does not block pairing.
- R5: A prefix flag on the V slot refuses the pair with count_o 1 and reason_o 4.
- R6: A branch flag on the U slot refuses the pair with count_o 1 and reason_o 5.
- R7: When the U slot is valid and the V slot is not, count_o is 1, pair_o is 0 and reason_o is 6.
- R8: When the U slot is not valid, count_o is 0, pair_o is 0 and reason_o is 7.
- R9: When several rules fail, reason_o reports the first failing rule in this order: class (1), dependency (2), displacement with immediate (3), prefix (4), branch (5).
- R10: stall_i is sampled on the rising clock edge. From that edge until the next one, count_o is 0, pair_o is 0 and reason_o is 7, whatever the slots hold. After reset the registered stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Stall request, registered before use |
| u_valid_i | input | 1 | Older slot holds an instruction |
| u_simple_i | input | 1 | Older slot is of the simple class |
| u_dst_i | input | NREG | Registers written by the older slot |
| u_disp_i | input | 1 | Older slot has a displacement |
| u_imm_i | input | 1 | Older slot has an immediate |
| u_branch_i | input | 1 | Older slot is a branch |
| v_valid_i | input | 1 | Younger slot holds an instruction |
| v_simple_i | input | 1 | Younger slot is of the simple class |
| v_src_i | input | NREG | Registers read by the younger slot |
| v_dst_i | input | NREG | Registers written by the younger slot |
| v_disp_i | input | 1 | Younger slot has a displacement |
| v_imm_i | input | 1 | Younger slot has an immediate |
| v_prefix_i | input | 1 | Younger slot carries a prefix |
| pair_o | output | 1 | Both instructions issue this clock |
| count_o | output | 2 | Instructions consumed this clock |
| reason_o | output | 3 | Outcome code per R1 to R9 |

## Verification
Slot-driven results are due in the same cycle the slot inputs change. The stall effect is due only after the next rising edge. The bench therefore changes every input on the falling edge and queues the expected result. The monitor compares five nanoseconds after the following rising edge, so a stall driven on that falling edge has already been registered, and the slot inputs are still steady, when the check is made.

// File: rtl/pair_pkg.sv
`timescale 1ns/1ps
package pair_pkg;
  localparam int unsigned NRULE = 5;
  localparam int unsigned RSN_W = 3;

  // rule index order is the report priority
  localparam int unsigned RULE_CLASS  = 0;
  localparam int unsigned RULE_DEP    = 1;
  localparam int unsigned RULE_DISPIM = 2;
  localparam int unsigned RULE_PREFIX = 3;
  localparam int unsigned RULE_BRANCH = 4;

  typedef enum logic [RSN_W-1:0] {
    RSN_PAIRED = 3'd0,
    RSN_CLASS  = 3'd1,
    RSN_DEP    = 3'd2,
    RSN_DISPIM = 3'd3,
    RSN_PREFIX = 3'd4,
    RSN_BRANCH = 3'd5,
    RSN_SOLO   = 3'd6,
    RSN_IDLE   = 3'd7
  } reason_e;
endpackage

// File: rtl/pair_dep.sv
`timescale 1ns/1ps
module pair_dep #(
  parameter int unsigned NREG = 8
) (
  input  logic [NREG-1:0] u_dst_i,
  input  logic [NREG-1:0] v_src_i,
  input  logic [NREG-1:0] v_dst_i,
  output logic            hit_o
);
  logic [NREG-1:0] hit_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit_vec[g] = u_dst_i[g] & (v_src_i[g] | v_dst_i[g]);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/pair_rules.sv
`timescale 1ns/1ps
module pair_rules
  import pair_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic             u_simple_i,
  input  logic [NREG-1:0]  u_dst_i,
  input  logic             u_disp_i,
  input  logic             u_imm_i,
  input  logic             u_branch_i,
  input  logic             v_simple_i,
  input  logic [NREG-1:0]  v_src_i,
  input  logic [NREG-1:0]  v_dst_i,
  input  logic             v_disp_i,
  input  logic             v_imm_i,
  input  logic             v_prefix_i,
  output logic [NRULE-1:0] fail_o
);
  logic dep_hit;

  pair_dep #(.NREG(NREG)) u_dep (
    .u_dst_i (u_dst_i),
    .v_src_i (v_src_i),
    .v_dst_i (v_dst_i),
    .hit_o   (dep_hit)
  );

  always_comb begin
    fail_o              = '0;
    fail_o[RULE_CLASS]  = !(u_simple_i && v_simple_i);
    fail_o[RULE_DEP]    = dep_hit;
    fail_o[RULE_DISPIM] = (u_disp_i && u_imm_i) || (v_disp_i && v_imm_i);
    fail_o[RULE_PREFIX] = v_prefix_i;
    fail_o[RULE_BRANCH] = u_branch_i;
  end
endmodule

// File: rtl/pair_prio.sv
`timescale 1ns/1ps
module pair_prio
  import pair_pkg::*;
(
  input  logic [NRULE-1:0] fail_i,
  output logic             any_o,
  output logic [RSN_W-1:0] code_o
);
  // lowest index wins; code is index+1
  always_comb begin
    code_o = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (fail_i[i]) code_o = RSN_W'(i + 1);
    end
  end

  assign any_o = |fail_i;
endmodule

// File: rtl/pair_check.sv
`timescale 1ns/1ps
module pair_check
  import pair_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            u_valid_i,
  input  logic            u_simple_i,
  input  logic [NREG-1:0] u_dst_i,
  input  logic            u_disp_i,
  input  logic            u_imm_i,
  input  logic            u_branch_i,
  input  logic            v_valid_i,
  input  logic            v_simple_i,
  input  logic [NREG-1:0] v_src_i,
  input  logic [NREG-1:0] v_dst_i,
  input  logic            v_disp_i,
  input  logic            v_imm_i,
  input  logic            v_prefix_i,
  output logic            pair_o,
  output logic [1:0]      count_o,
  output logic [2:0]      reason_o
);
  logic             stall_q;
  logic [NRULE-1:0] fail;
  logic             any_fail;
  logic [RSN_W-1:0] fail_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_i;
  end

  pair_rules #(.NREG(NREG)) u_rules (
    .u_simple_i (u_simple_i),
    .u_dst_i    (u_dst_i),
    .u_disp_i   (u_disp_i),
    .u_imm_i    (u_imm_i),
    .u_branch_i (u_branch_i),
    .v_simple_i (v_simple_i),
    .v_src_i    (v_src_i),
    .v_dst_i    (v_dst_i),
    .v_disp_i   (v_disp_i),
    .v_imm_i    (v_imm_i),
    .v_prefix_i (v_prefix_i),
    .fail_o     (fail)
  );

  pair_prio u_prio (
    .fail_i (fail),
    .any_o  (any_fail),
    .code_o (fail_code)
  );

  always_comb begin
    pair_o   = 1'b0;
    count_o  = 2'd0;
    reason_o = RSN_IDLE;
    if (stall_q || !u_valid_i) begin
      reason_o = RSN_IDLE;
    end else if (!v_valid_i) begin
      count_o  = 2'd1;
      reason_o = RSN_SOLO;
    end else if (any_fail) begin
      count_o  = 2'd1;
      reason_o = fail_code;
    end else begin
      pair_o   = 1'b1;
      count_o  = 2'd2;
      reason_o = RSN_PAIRED;
    end
  end

  // R1
  pair_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> (count_o == 2'd2) && v_valid_i && u_valid_i);
  // R2
  pair_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> u_simple_i && v_simple_i);
  // R3
  pair_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> ((v_src_i | v_dst_i) & u_dst_i) == '0);
  // R4
  pair_dispim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> !(u_disp_i && u_imm_i) && !(v_disp_i && v_imm_i));
  // R5
  pair_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> !v_prefix_i);
  // R6
  pair_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> !u_branch_i);
  // R8
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !u_valid_i |-> count_o == 2'd0);
endmodule

// File: tb/sim_pair_check.sv
`timescale 1ns/1ps
module sim_pair_check;
  localparam int unsigned NREG = 8;

  typedef struct packed {
    logic            valid;
    logic            simple;
    logic [NREG-1:0] src;
    logic [NREG-1:0] dst;
    logic            disp;
    logic            imm;
    logic            prefix;
    logic            branch;
  } ins_t;

  typedef struct packed {
    logic       pair;
    logic [1:0] cnt;
    logic [2:0] rsn;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  ins_t u_in = '0, v_in = '0;
  logic       pair;
  logic [1:0] cnt;
  logic [2:0] rsn;

  int total = 0, bad = 0;
  res_t   exp_q[$];
  string  tag_q[$];

  always #10 clk = ~clk;

  pair_check #(.NREG(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .u_valid_i(u_in.valid), .u_simple_i(u_in.simple), .u_dst_i(u_in.dst),
    .u_disp_i(u_in.disp), .u_imm_i(u_in.imm), .u_branch_i(u_in.branch),
    .v_valid_i(v_in.valid), .v_simple_i(v_in.simple), .v_src_i(v_in.src),
    .v_dst_i(v_in.dst), .v_disp_i(v_in.disp), .v_imm_i(v_in.imm),
    .v_prefix_i(v_in.prefix),
    .pair_o(pair), .count_o(cnt), .reason_o(rsn)
  );

  function automatic res_t model(ins_t u, ins_t v, logic st);
    res_t r;
    r = '{pair: 1'b0, cnt: 2'd0, rsn: 3'd7};
    if (st || !u.valid) return r;
    r.cnt = 2'd1;
    if (!v.valid) begin r.rsn = 3'd6; return r; end
    if (!(u.simple && v.simple))                   r.rsn = 3'd1;
    else if ((u.dst & (v.src | v.dst)) != '0)      r.rsn = 3'd2;
    else if ((u.disp && u.imm) || (v.disp && v.imm)) r.rsn = 3'd3;
    else if (v.prefix)                             r.rsn = 3'd4;
    else if (u.branch)                             r.rsn = 3'd5;
    else begin r.pair = 1'b1; r.cnt = 2'd2; r.rsn = 3'd0; end
    return r;
  endfunction

  function automatic ins_t mk(logic [NREG-1:0] src, logic [NREG-1:0] dst);
    ins_t i = '0;
    i.valid = 1'b1; i.simple = 1'b1; i.src = src; i.dst = dst;
    return i;
  endfunction

  task automatic drive(ins_t u, ins_t v, logic st, string tag);
    @(negedge clk);
    u_in = u; v_in = v; stall = st;
    exp_q.push_back(model(u, v, st));
    tag_q.push_back(tag);
  endtask

  // monitor: results due 5 ns after the edge following the drive
  always @(posedge clk) begin
    #5;
    if (rst_n && exp_q.size() > 0) begin
      res_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({pair, cnt, rsn} !== e) begin
        bad++;
        $display("FAIL %s: got pair=%b cnt=%0d rsn=%0d exp pair=%b cnt=%0d rsn=%0d",
                 t, pair, cnt, rsn, e.pair, e.cnt, e.rsn);
      end
    end
  end

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog: got hung exp finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ins_t a, b;
    repeat (3) @(posedge clk);
    #5;
    total++;
    if ({pair, cnt, rsn} !== {1'b0, 2'd0, 3'd7}) begin
      bad++;
      $display("FAIL R8 reset: got %b %0d %0d exp 0 0 7", pair, cnt, rsn);
    end
    @(negedge clk);
    rst_n = 1'b1;

    drive(mk(8'h01, 8'h02), mk(8'h04, 8'h08), 1'b0, "R1 independent pair");
    a = mk(8'h10, 8'h20); b = mk(8'h40, 8'h80);
    drive(a, b, 1'b0, "R1 second pair");
    a = mk(0, 8'h01); a.simple = 1'b0;
    drive(a, mk(0, 8'h02), 1'b0, "R2 u complex");
    b = mk(0, 8'h02); b.simple = 1'b0;
    drive(mk(0, 8'h01), b, 1'b0, "R2 v complex");
    drive(mk(0, 8'h01), mk(8'h01, 8'h02), 1'b0, "R3 read after write");
    drive(mk(0, 8'h04), mk(0, 8'h04), 1'b0, "R3 write after write");
    drive(mk(8'h08, 8'h01), mk(0, 8'h08), 1'b0, "R3 u reads v dst pairs");
    a = mk(0, 8'h01); a.disp = 1'b1; a.imm = 1'b1;
    drive(a, mk(0, 8'h02), 1'b0, "R4 u disp+imm");
    b = mk(0, 8'h02); b.disp = 1'b1; b.imm = 1'b1;
    drive(mk(0, 8'h01), b, 1'b0, "R4 v disp+imm");
    a = mk(0, 8'h01); a.disp = 1'b1; b = mk(0, 8'h02); b.imm = 1'b1;
    drive(a, b, 1'b0, "R4 split disp/imm pairs");
    b = mk(0, 8'h02); b.prefix = 1'b1;
    drive(mk(0, 8'h01), b, 1'b0, "R5 v prefixed");
    a = mk(0, 8'h01); a.branch = 1'b1;
    drive(a, mk(0, 8'h02), 1'b0, "R6 u branch");
    drive(mk(0, 8'h01), '0, 1'b0, "R7 v empty");
    a = '0; a.dst = 8'h01;
    drive(a, mk(0, 8'h02), 1'b0, "R8 u empty");
    a = mk(0, 8'h01); a.simple = 1'b0;
    drive(a, mk(8'h01, 8'h02), 1'b0, "R9 class over dep");
    b = mk(8'h01, 8'h02); b.prefix = 1'b1;
    drive(mk(0, 8'h01), b, 1'b0, "R9 dep over prefix");
    a = mk(0, 8'h01); a.branch = 1'b1; a.disp = 1'b1; a.imm = 1'b1;
    b = mk(0, 8'h02); b.prefix = 1'b1;
    drive(a, b, 1'b0, "R9 dispim over prefix");
    a = mk(0, 8'h01); a.branch = 1'b1;
    drive(a, b, 1'b0, "R9 prefix over branch");
    drive(mk(8'h01, 8'h02), mk(8'h04, 8'h08), 1'b1, "R10 stall blocks pair");
    drive(mk(0, 8'h01), '0, 1'b1, "R10 stall blocks solo");
    drive(mk(8'h01, 8'h02), mk(8'h04, 8'h08), 1'b0, "R10 stall released");
    for (int k = 0; k < 40; k++) begin
      a = mk(NREG'(k * 37), NREG'(1 << (k % NREG)));
      b = mk(NREG'(k * 11), NREG'(k * 5));
      a.branch = (k % 7) == 0; b.prefix = (k % 5) == 0;
      b.simple = (k % 9) != 0; a.valid = (k % 13) != 0;
      drive(a, b, (k % 11) == 0, "R9 sweep");
    end
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule